// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a video output from a set of programmed limits. A horizontal pixel counter and a vertical line counter run on the pixel clock. Compares against those counters give the visible-area window, the horizontal and vertical sync pulses, and an early per-line pulse. That pulse tells a pixel fetch engine to start loading the next line ahead of time. All limits are written as the last count value, which is the length minus one.

The sync outputs pass through a conditioning stage before they leave the block. This stage can invert each pulse, hold either pulse at its idle level for power-saving modes, or turn both off. It can also drive a composite sync for the green channel. A separate display-off flag blanks the video window while the counters and sync carry on.

Timing limits are captured into internal copies at the start of each frame, so software may rewrite them at any time without tearing the current frame. The control word and the sync conditioning bits act at once.

Top module: `disp_timing_gen`

## Requirements
- R1: While control bit 0 (run) is clear, both counters are held at zero, `video_active` and `prefetch` are low, and the un-inverted sync pulses are idle.
- R2: While running, `pix_x` counts 0 to `h_total` and then wraps to 0. `line_y` advances by one at each wrap and returns to 0 after line `v_total`.
- R3: `video_active` is high exactly when `pix_x <= h_visible` and `line_y <= v_visible`, with run set, control bit 1 (refresh) set and `disp_off` low.
- R4: The un-inverted hsync is high when `hs_begin < pix_x <= hs_finish`. The un-inverted vsync is high when `vs_begin < line_y <= vs_finish`.
- R5: `sync_ctl` bit 3 inverts `hsync` and bit 4 inverts `vsync`.
- R6: `sync_ctl` bit 5 holds hsync at its idle level and bit 6 holds vsync at its idle level. Bit 1 holds both at their idle level. The idle level is the inversion bit.
- R7: When `sync_ctl` bit 0 is set, `csync_green` equals `hsync` XOR `vsync` as driven on the ports. Otherwise it is low.
- R8: `disp_off` high forces `video_active` low while the counters and sync keep running.
- R9: `prefetch` is high for one cycle on every line, visible or blank. It occurs at `pix_x == h_total - pf_lead`, and at `pix_x == 0` when `pf_lead > h_total`.
- R10: Timing limits are taken up at the first cycle of a frame, and on every cycle while stopped. A change in mid-frame leaves the current frame unchanged. `sync_ctl` and `disp_off` act on the same cycle.
- R11: With run set and refresh clear, the counters and sync run and `video_active` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 2 | Bit 0 run, bit 1 refresh |
| sync_ctl | input | 7 | Sync conditioning: 0 composite, 1 all off, 3 h invert, 4 v invert, 5 h off, 6 v off |
| disp_off | input | 1 | Blank video, keep sync |
| h_total | input | HW | Pixels per line minus one |
| h_visible | input | HW | Visible width minus one |
| hs_begin | input | HW | Last pixel before hsync |
| hs_finish | input | HW | Last hsync pixel |
| pf_lead | input | HW | Prefetch lead in pixels |
| v_total | input | VW | Lines per frame minus one |
| v_visible | input | VW | Visible height minus one |
| vs_begin | input | VW | Last line before vsync |
| vs_finish | input | VW | Last vsync line |
| hsync | output | 1 | Conditioned horizontal sync |
| vsync | output | 1 | Conditioned vertical sync |
| csync_green | output | 1 | Composite sync for green channel |
| video_active | output | 1 | Visible-area window |
| pix_x | output | HW | Pixel counter |
| line_y | output | VW | Line counter |
| prefetch | output | 1 | Early line fetch pulse |

## Verification
A counter that steps wrongly shows on `pix_x` or `line_y` at the very next sample. A mis-captured limit copy shows up later: the frame still runs on the old values, and the first wrong wrap or sync edge appears within one frame of the register change. A faulty conditioning term shows on `hsync`, `vsync` or `csync_green` in the same cycle its control bit changes, because that stage holds no state. The bench tracks the raster with its own line and frame arithmetic and compares every output on every cycle, so any of these faults surfaces within one frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // control word bit positions
  localparam int CW_RUN     = 0;
  localparam int CW_REFRESH = 1;
  // sync conditioning bit positions
  localparam int SC_COMPOSITE = 0;
  localparam int SC_ALL_OFF   = 1;
  localparam int SC_H_INV     = 3;
  localparam int SC_V_INV     = 4;
  localparam int SC_H_OFF     = 5;
  localparam int SC_V_OFF     = 6;
  localparam int SC_WIDTH     = 7;

  typedef struct packed {
    logic cntEn;
    logic vidEn;
    logic hsKill;
    logic vsKill;
    logic hsInv;
    logic vsInv;
    logic csyncEn;
  } dtgStrobeT;

  typedef struct packed {
    logic hVis;
    logic vVis;
    logic hSync;
    logic vSync;
    logic pfHit;
  } dtgFlagT;
endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
(
  input  logic [1:0]          ctrlWord,
  input  logic [SC_WIDTH-1:0] syncCtl,
  input  logic                dispOff,
  output dtgStrobeT           strb
);
  always_comb begin
    strb.cntEn   = ctrlWord[CW_RUN];
    strb.vidEn   = ctrlWord[CW_REFRESH] & ~dispOff;
    strb.hsKill  = syncCtl[SC_H_OFF] | syncCtl[SC_ALL_OFF];
    strb.vsKill  = syncCtl[SC_V_OFF] | syncCtl[SC_ALL_OFF];
    strb.hsInv   = syncCtl[SC_H_INV];
    strb.vsInv   = syncCtl[SC_V_INV];
    strb.csyncEn = syncCtl[SC_COMPOSITE];
  end
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntEn,
  input  logic [HW-1:0] hTotIn,
  input  logic [HW-1:0] hVisIn,
  input  logic [HW-1:0] hsBegIn,
  input  logic [HW-1:0] hsEndIn,
  input  logic [HW-1:0] pfLeadIn,
  input  logic [VW-1:0] vTotIn,
  input  logic [VW-1:0] vVisIn,
  input  logic [VW-1:0] vsBegIn,
  input  logic [VW-1:0] vsEndIn,
  output logic [HW-1:0] hCnt,
  output logic [VW-1:0] vCnt,
  output dtgFlagT       flags
);
  localparam int NH = 4;  // captured horizontal limits
  localparam int NV = 4;  // captured vertical limits

  logic [HW-1:0] hLim [NH];
  logic [VW-1:0] vLim [NV];
  logic [HW-1:0] hNext [NH];
  logic [VW-1:0] vNext [NV];
  logic [HW-1:0] pfCmp;
  logic          lineEnd, frameEnd, capture;

  // clamp: a lead longer than the line fires at pixel zero
  assign pfCmp = (pfLeadIn > hTotIn) ? '0 : hTotIn - pfLeadIn;

  assign hNext[0] = hTotIn;
  assign hNext[1] = hVisIn;
  assign hNext[2] = hsBegIn;
  assign hNext[3] = hsEndIn;
  assign vNext[0] = vTotIn;
  assign vNext[1] = vVisIn;
  assign vNext[2] = vsBegIn;
  assign vNext[3] = vsEndIn;

  logic [HW-1:0] pfLim;

  assign lineEnd  = (hCnt == hLim[0]);
  assign frameEnd = lineEnd && (vCnt == vLim[0]);
  assign capture  = !cntEn || frameEnd;

  for (genvar i = 0; i < NH; i++) begin : gHCap
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)        hLim[i] <= '0;
      else if (capture) hLim[i] <= hNext[i];
  end
  for (genvar i = 0; i < NV; i++) begin : gVCap
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)        vLim[i] <= '0;
      else if (capture) vLim[i] <= vNext[i];
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        pfLim <= '0;
    else if (capture) pfLim <= pfCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!cntEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= (vCnt == vLim[0]) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    flags.hVis  = hCnt <= hLim[1];
    flags.vVis  = vCnt <= vLim[1];
    flags.hSync = (hCnt > hLim[2]) && (hCnt <= hLim[3]);
    flags.vSync = (vCnt > vLim[2]) && (vCnt <= vLim[3]);
    flags.pfHit = hCnt == pfLim;
  end

  // R1: stopped counters sit at zero
  assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (hCnt == '0 && vCnt == '0));
  // R2: pixel counter never passes the captured line length
  assert_h_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    hCnt <= hLim[0]);
  // R2: last pixel of a line is followed by pixel zero
  assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && hCnt == hLim[0]) |=> hCnt == '0);
  // R9: prefetch compare is a single-cycle event on lines longer than one pixel
  assert_pf_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && flags.pfHit && hLim[0] != '0) |=> !flags.pfHit);
  // R10: captured limits stay put inside a running frame
  assert_limits_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !frameEnd) |=> ($stable(hLim[0]) && $stable(vLim[0]) && $stable(pfLim)));
endmodule

// File: rtl/dtg_outstage.sv
module dtg_outstage
  import dtg_pkg::*;
(
  input  dtgStrobeT strb,
  input  dtgFlagT   flags,
  output logic      hsync,
  output logic      vsync,
  output logic      csync,
  output logic      active,
  output logic      prefetch
);
  logic hRaw, vRaw;

  always_comb begin
    hRaw     = strb.cntEn & flags.hSync & ~strb.hsKill;
    vRaw     = strb.cntEn & flags.vSync & ~strb.vsKill;
    hsync    = hRaw ^ strb.hsInv;
    vsync    = vRaw ^ strb.vsInv;
    csync    = strb.csyncEn & (hsync ^ vsync);
    active   = strb.cntEn & strb.vidEn & flags.hVis & flags.vVis;
    prefetch = strb.cntEn & flags.pfHit;
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ctrl_word,
  input  logic [SC_WIDTH-1:0] sync_ctl,
  input  logic                disp_off,
  input  logic [HW-1:0]       h_total,
  input  logic [HW-1:0]       h_visible,
  input  logic [HW-1:0]       hs_begin,
  input  logic [HW-1:0]       hs_finish,
  input  logic [HW-1:0]       pf_lead,
  input  logic [VW-1:0]       v_total,
  input  logic [VW-1:0]       v_visible,
  input  logic [VW-1:0]       vs_begin,
  input  logic [VW-1:0]       vs_finish,
  output logic                hsync,
  output logic                vsync,
  output logic                csync_green,
  output logic                video_active,
  output logic [HW-1:0]       pix_x,
  output logic [VW-1:0]       line_y,
  output logic                prefetch
);
  dtgStrobeT strb;
  dtgFlagT   flags;

  dtg_ctrl uCtrl (
    .ctrlWord (ctrl_word),
    .syncCtl  (sync_ctl),
    .dispOff  (disp_off),
    .strb     (strb)
  );

  dtg_counters #(.HW(HW), .VW(VW)) uCnt (
    .clk      (clk),
    .rstN     (rst_n),
    .cntEn    (strb.cntEn),
    .hTotIn   (h_total),
    .hVisIn   (h_visible),
    .hsBegIn  (hs_begin),
    .hsEndIn  (hs_finish),
    .pfLeadIn (pf_lead),
    .vTotIn   (v_total),
    .vVisIn   (v_visible),
    .vsBegIn  (vs_begin),
    .vsEndIn  (vs_finish),
    .hCnt     (pix_x),
    .vCnt     (line_y),
    .flags    (flags)
  );

  dtg_outstage uOut (
    .strb     (strb),
    .flags    (flags),
    .hsync    (hsync),
    .vsync    (vsync),
    .csync    (csync_green),
    .active   (video_active),
    .prefetch (prefetch)
  );
endmodule

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ctrl_word = '0;
  logic [6:0] sync_ctl = '0;
  logic disp_off = 1'b0;
  logic [HW-1:0] h_total = '0, h_visible = '0, hs_begin = '0, hs_finish = '0, pf_lead = '0;
  logic [VW-1:0] v_total = '0, v_visible = '0, vs_begin = '0, vs_finish = '0;
  logic hsync, vsync, csync_green, video_active, prefetch;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] line_y;

  disp_timing_gen #(.HW(HW), .VW(VW)) uut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nFails = 0;
  string phase = "init";

  // bench raster model
  int mh = 0, mv = 0;
  int cHT = 0, cHD = 0, cHS = 0, cHE = 0, cPF = 0;
  int cVT = 0, cVD = 0, cVS = 0, cVE = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s [%s]: actual %0d expected %0d", req, what, phase, act, exp);
    end
  endtask

  task automatic takeLimits();
    cHT = int'(h_total); cHD = int'(h_visible); cHS = int'(hs_begin);
    cHE = int'(hs_finish); cPF = int'(pf_lead);
    cVT = int'(v_total); cVD = int'(v_visible); cVS = int'(vs_begin);
    cVE = int'(vs_finish);
  endtask

  task automatic stepModel();
    if (!rst_n || !ctrl_word[0]) begin
      mh = 0; mv = 0; takeLimits();
    end else if (mh == cHT) begin
      mh = 0;
      if (mv == cVT) begin mv = 0; takeLimits(); end
      else mv = mv + 1;
    end else mh = mh + 1;
  endtask

  task automatic checkAll();
    bit run, hOn, vOn, eH, eV, eC, eA, eP;
    int lineLen, pfAt;
    run = rst_n && ctrl_word[0];
    hOn = run && (mh > cHS) && (mh <= cHE) && !sync_ctl[5] && !sync_ctl[1];
    vOn = run && (mv > cVS) && (mv <= cVE) && !sync_ctl[6] && !sync_ctl[1];
    eH = hOn ^ sync_ctl[3];
    eV = vOn ^ sync_ctl[4];
    eC = sync_ctl[0] ? (eH ^ eV) : 1'b0;
    eA = run && ctrl_word[1] && !disp_off && (mh <= cHD) && (mv <= cVD);
    lineLen = cHT + 1;
    pfAt = lineLen - cPF - 1;
    if (pfAt < 0) pfAt = 0;
    eP = run && (mh == pfAt);
    chk("R2", "pix_x", int'(pix_x), mh);
    chk("R2", "line_y", int'(line_y), mv);
    chk("R3", "video_active", int'(video_active), int'(eA));
    chk("R4", "hsync", int'(hsync), int'(eH));
    chk("R4", "vsync", int'(vsync), int'(eV));
    chk("R7", "csync_green", int'(csync_green), int'(eC));
    chk("R9", "prefetch", int'(prefetch), int'(eP));
  endtask

  task automatic cycle();
    @(posedge clk);
    stepModel();
    @(negedge clk);
    checkAll();
  endtask

  task automatic runN(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic cfgA();
    h_total = 19; h_visible = 11; hs_begin = 13; hs_finish = 16; pf_lead = 5;
    v_total = 9;  v_visible = 4;  vs_begin = 5;  vs_finish = 7;
  endtask

  task automatic cfgB();
    h_total = 15; h_visible = 7; hs_begin = 9; hs_finish = 11; pf_lead = 20;
    v_total = 7;  v_visible = 3; vs_begin = 4; vs_finish = 5;
  endtask

  bit done = 0;
  int pfCount;

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    cfgA();
    // R1 reset state
    phase = "R1 reset";
    @(negedge clk);
    checkAll();
    runN(2);
    rst_n = 1'b1;
    runN(3);

    // R2 R3 R4 R9: plain run, two frames
    phase = "R2 R3 R4 R9 base";
    ctrl_word = 2'b11;
    runN(400);

    // R9: one prefetch per line over a frame
    phase = "R9 count";
    pfCount = 0;
    for (int i = 0; i < 200; i++) begin
      cycle();
      if (prefetch) pfCount++;
    end
    chk("R9", "prefetch per frame", pfCount, 10);

    phase = "R5 invert"; sync_ctl = 7'h18; runN(200);
    phase = "R6 h off";  sync_ctl = 7'h20; runN(200);
    phase = "R6 v off";  sync_ctl = 7'h58; runN(200);
    phase = "R6 all off"; sync_ctl = 7'h0A; runN(200);
    phase = "R7 composite"; sync_ctl = 7'h01; runN(200);
    phase = "R7 composite inv"; sync_ctl = 7'h19; runN(200);
    sync_ctl = 7'h00;

    phase = "R8 display off"; disp_off = 1'b1; runN(200);
    disp_off = 1'b0;
    phase = "R11 refresh clear"; ctrl_word = 2'b01; runN(200);
    ctrl_word = 2'b11;

    // R10: change limits mid-frame, old frame finishes first
    phase = "R10 mid-frame change";
    runN(73);
    cfgB();
    runN(300);
    // R9 clamp: lead longer than line fires at pixel zero
    phase = "R9 clamp";
    runN(130);
    phase = "R9 zero lead"; pf_lead = 0; runN(260);

    // R1: stop, counters held, then restart
    phase = "R1 stopped";
    ctrl_word = 2'b10;
    runN(40);
    chk("R1", "pix_x stopped", int'(pix_x), 0);
    cfgA();
    phase = "R1 restart";
    ctrl_word = 2'b11;
    runN(250);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule